// File: doc/BRIEF.md
# PCI Bridge Error Signalling Controller

This block sits on the PCI side of a bridge and decides how error events are reported to the rest of the system. It receives single-cycle event pulses from the bus logic for these conditions:

- an address parity error;
- a data parity error in an inbound transaction;
- a data parity error in an outbound transaction;
- an observed PERR#;
- an inbound read discard-timer expiry;
- a fatal condition that may call for a bus initialisation.

It also receives the SERR and parity-response enables from the PCI command register. From these inputs it drives a system-error output and an exact copy of it, a one-shot bus-initialisation output and a level interrupt request.

Software controls the block through two registers on a simple register port:

- **Command register (16 bits).** It holds one enable bit for each reporting path and an override bit that stops bus initialisation. The block sets the override bit itself after it has issued one bus initialisation, so a fatal condition causes at most one such pulse until software re-arms it.
- **First-error register (8 bits).** It records only the earliest event and then holds that record until software clears it with write-1-to-clear writes.

Top module: `pci_err_signal_ctl`

## Requirements
- R1: After reset the command register reads 0x8040, the first-error register reads 0x00, and `serr_o`, `serr_copy_o`, `bus_init_o` and `irq_o` are low.
- R2: The register port selects the command register with `reg_sel`=0 and the first-error register with `reg_sel`=1. A write is taken on the clock edge where `reg_wr` is high. In the command register only bits 15, 13, 12, 11 and 10 are writable. Bit 6 always reads 1 and bits 14, 9:7 and 5:0 always read 0, whatever is written.
- R3: When `ev_fatal` is high and command bit 15 is 0, `bus_init_o` is high for exactly the following cycle and bit 15 becomes 1. While bit 15 is 1, `ev_fatal` has no effect. If a software write lands on the same edge as this hardware set, the hardware set wins.
- R4: An address parity event raises SERR only if command bit 12, `cfg_serr_en` and `cfg_perr_en` are all set.
- R5: An inbound data parity event raises SERR only if command bit 11 and `cfg_serr_en` are set.
- R6: A discard-timer event raises SERR only if command bit 10 and `cfg_serr_en` are set. Outbound parity and PERR# events never raise SERR.
- R7: `serr_o` goes high in the cycle after a qualifying event and stays high for one cycle per event cycle. `serr_copy_o` equals `serr_o` in every cycle.
- R8: The first-error register uses bit 0 for address parity, bit 1 for inbound data parity, bit 2 for outbound data parity, bit 3 for PERR# observed and bit 4 for discard timeout. It records an event only while the whole register is zero. If several events arrive together, only the lowest-numbered bit is set. Events arriving while the register is nonzero are ignored.
- R9: Writing the first-error register clears each bit written as 1 and leaves unchanged each bit written as 0.
- R10: `irq_o` is high whenever command bit 13 is set and first-error bit 2 or bit 3 is set. It follows those register bits in the same cycle.
- R11: Bits 7:5 of the first-error register and bits 15:8 of the status read data always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_addr_par | input | 1 | Address parity error pulse |
| ev_in_dpar | input | 1 | Inbound data parity error pulse |
| ev_out_dpar | input | 1 | Outbound data parity error pulse |
| ev_perr_seen | input | 1 | Observed PERR# pulse |
| ev_discard | input | 1 | Inbound read discard-timer expiry pulse |
| ev_fatal | input | 1 | Fatal condition requesting bus initialisation |
| cfg_serr_en | input | 1 | SERR enable from the PCI command register |
| cfg_perr_en | input | 1 | Parity-response enable from the PCI command register |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 first-error |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |
| serr_o | output | 1 | System error output |
| serr_copy_o | output | 1 | Exact copy of the system error output |
| bus_init_o | output | 1 | One-cycle bus initialisation pulse |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default widths: a 16-bit command register, an 8-bit first-error register and five event sources. Because there are only five sources, the bench can drive every combination of them. For each combination it also tries all eight settings of the three SERR source enables and all four settings of the two PCI enables. This covers every layering of the SERR qualification and every tie case of the lowest-bit capture rule. Separate directed sequences exercise the freeze, the write-1-to-clear masks, the self-setting override and its race with a software write, and the interrupt level.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

  localparam int CMD_W  = 16;
  localparam int STAT_W = 8;
  localparam int NSRC   = 5;

  localparam logic [CMD_W-1:0] CMD_RST   = 16'h8040;
  localparam logic [CMD_W-1:0] CMD_WMASK = 16'hBC00;

  localparam int CB_OVR  = 15;
  localparam int CB_IRQE = 13;
  localparam int CB_APE  = 12;
  localparam int CB_IDE  = 11;
  localparam int CB_DTE  = 10;

  localparam int SRC_ADDR   = 0;
  localparam int SRC_IN_DP  = 1;
  localparam int SRC_OUT_DP = 2;
  localparam int SRC_PERR   = 3;
  localparam int SRC_DISC   = 4;

  typedef struct packed {
    logic ovr;
    logic irqe;
    logic ape;
    logic ide;
    logic dte;
  } cmd_ctl_t;

endpackage

// File: rtl/errsig_cmd_reg.sv
module errsig_cmd_reg
  import pci_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wdata,
  input  logic             ovr_set,
  output logic [CMD_W-1:0] value,
  output cmd_ctl_t         ctl
);

  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_en) begin
      cmd_d = (cmd_q & ~CMD_WMASK) | (wdata & CMD_WMASK);
    end
    if (ovr_set) begin
      cmd_d[CB_OVR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST;
    end else if (wr_en || ovr_set) begin
      cmd_q <= cmd_d;
    end
  end

  assign value    = cmd_q;
  assign ctl.ovr  = cmd_q[CB_OVR];
  assign ctl.irqe = cmd_q[CB_IRQE];
  assign ctl.ape  = cmd_q[CB_APE];
  assign ctl.ide  = cmd_q[CB_IDE];
  assign ctl.dte  = cmd_q[CB_DTE];

  AST_OVR_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> cmd_q[CB_OVR]) else $error("override not set"); // R3

endmodule

// File: rtl/errsig_first_err.sv
module errsig_first_err #(
  parameter int STAT_W = 8,
  parameter int NSRC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   ev,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status
);

  logic [STAT_W-1:0] st_q;
  logic [STAT_W-1:0] st_d;
  logic [NSRC-1:0]   seen_lower;
  logic [NSRC-1:0]   pick;

  for (genvar g = 0; g < NSRC; g++) begin : g_prio
    if (g == 0) begin : g_first
      assign seen_lower[g] = 1'b0;
    end else begin : g_rest
      assign seen_lower[g] = seen_lower[g-1] | ev[g-1];
    end
    assign pick[g] = ev[g] & ~seen_lower[g];
  end

  always_comb begin
    st_d = st_q;
    if (st_q == '0) begin
      st_d[NSRC-1:0] = pick;
    end else if (clr_en) begin
      st_d = st_q & ~clr_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign status = st_q;

  AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_q)) else $error("more than one first-error bit"); // R8
  AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != '0) && !clr_en) |=> $stable(st_q)) else $error("frozen record changed"); // R8
  AST_W1C_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != '0) |=> ((st_q & ~$past(st_q)) == '0)) else $error("bit set while frozen"); // R9

endmodule

// File: rtl/errsig_out_gen.sv
module errsig_out_gen
  import pci_err_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_addr,
  input  logic     ev_in_dp,
  input  logic     ev_disc,
  input  logic     ev_fatal,
  input  logic     serr_en,
  input  logic     perr_en,
  input  cmd_ctl_t ctl,
  input  logic     st_out_dp,
  input  logic     st_perr,
  output logic     serr,
  output logic     bus_init,
  output logic     irq,
  output logic     ovr_set
);

  logic serr_q, serr_d;
  logic binit_q, binit_d;

  always_comb begin
    serr_d = serr_en & ((ev_addr & ctl.ape & perr_en) |
                        (ev_in_dp & ctl.ide) |
                        (ev_disc & ctl.dte));
    binit_d = ev_fatal & ~ctl.ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_q  <= 1'b0;
      binit_q <= 1'b0;
    end else begin
      serr_q  <= serr_d;
      binit_q <= binit_d;
    end
  end

  assign serr     = serr_q;
  assign bus_init = binit_q;
  assign ovr_set  = binit_d;
  assign irq      = ctl.irqe & (st_out_dp | st_perr);

  AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    serr_q |-> $past(serr_en)) else $error("SERR without enable"); // R5
  AST_BUSINIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ovr |=> !binit_q) else $error("bus init while overridden"); // R3

endmodule

// File: rtl/pci_err_signal_ctl.sv
module pci_err_signal_ctl
  import pci_err_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_addr_par,
  input  logic        ev_in_dpar,
  input  logic        ev_out_dpar,
  input  logic        ev_perr_seen,
  input  logic        ev_discard,
  input  logic        ev_fatal,
  input  logic        cfg_serr_en,
  input  logic        cfg_perr_en,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        serr_o,
  output logic        serr_copy_o,
  output logic        bus_init_o,
  output logic        irq_o
);

  localparam int PAD_W = CMD_W - STAT_W;

  logic [NSRC-1:0]   ev_vec;
  logic [CMD_W-1:0]  cmd_val;
  logic [STAT_W-1:0] stat_val;
  cmd_ctl_t          ctl;
  logic              ovr_set;
  logic              serr_int;

  always_comb begin
    ev_vec             = '0;
    ev_vec[SRC_ADDR]   = ev_addr_par;
    ev_vec[SRC_IN_DP]  = ev_in_dpar;
    ev_vec[SRC_OUT_DP] = ev_out_dpar;
    ev_vec[SRC_PERR]   = ev_perr_seen;
    ev_vec[SRC_DISC]   = ev_discard;
  end

  errsig_cmd_reg u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr & ~reg_sel),
    .wdata   (reg_wdata),
    .ovr_set (ovr_set),
    .value   (cmd_val),
    .ctl     (ctl)
  );

  errsig_first_err #(.STAT_W(STAT_W), .NSRC(NSRC)) u_first (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_vec),
    .clr_en   (reg_wr & reg_sel),
    .clr_mask (reg_wdata[STAT_W-1:0]),
    .status   (stat_val)
  );

  errsig_out_gen u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_addr   (ev_addr_par),
    .ev_in_dp  (ev_in_dpar),
    .ev_disc   (ev_discard),
    .ev_fatal  (ev_fatal),
    .serr_en   (cfg_serr_en),
    .perr_en   (cfg_perr_en),
    .ctl       (ctl),
    .st_out_dp (stat_val[SRC_OUT_DP]),
    .st_perr   (stat_val[SRC_PERR]),
    .serr      (serr_int),
    .bus_init  (bus_init_o),
    .irq       (irq_o),
    .ovr_set   (ovr_set)
  );

  assign serr_o      = serr_int;
  assign serr_copy_o = serr_int;
  assign reg_rdata   = reg_sel ? {{PAD_W{1'b0}}, stat_val} : cmd_val;

  AST_BUSINIT_ARMS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init_o |-> cmd_val[CB_OVR]) else $error("override clear after bus init"); // R3
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_val[SRC_OUT_DP] || stat_val[SRC_PERR])) else $error("irq without source"); // R10

endmodule

// File: tb/pci_err_signal_ctl_tb_top.sv
`timescale 1ns/1ps
module pci_err_signal_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ev = '0;
  logic        ev_fatal = 1'b0;
  logic        cfg_serr_en = 1'b0;
  logic        cfg_perr_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        serr_o, serr_copy_o, bus_init_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_err_signal_ctl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_addr_par  (ev[0]),
    .ev_in_dpar   (ev[1]),
    .ev_out_dpar  (ev[2]),
    .ev_perr_seen (ev[3]),
    .ev_discard   (ev[4]),
    .ev_fatal     (ev_fatal),
    .cfg_serr_en  (cfg_serr_en),
    .cfg_perr_en  (cfg_perr_en),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .serr_o       (serr_o),
    .serr_copy_o  (serr_copy_o),
    .bus_init_o   (bus_init_o),
    .irq_o        (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic reg_write(input logic sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic sel, output logic [15:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // drive events for one cycle; returns at posedge+2 so outputs can be sampled
  task automatic fire(input logic [4:0] e, input logic f);
    ev = e; ev_fatal = f;
    @(posedge clk);
    #2;
  endtask

  task automatic release_ev();
    @(negedge clk);
    ev = '0; ev_fatal = 1'b0;
  endtask

  function automatic logic [7:0] lowest(input logic [4:0] e);
    for (int i = 0; i < 5; i++) begin
      if (e[i]) return 8'(1 << i);
    end
    return 8'h00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_reg(1'b0, rd); check("R1 cmd reset", rd, 16'h8040);
    read_reg(1'b1, rd); check("R1 status reset", rd, 16'h0000);
    check("R1 outputs", {serr_o, serr_copy_o, bus_init_o, irq_o}, 4'b0000);

    // R2 writable mask and reserved bits
    reg_write(1'b0, 16'hFFFF); read_reg(1'b0, rd); check("R2 all ones", rd, 16'hBC40);
    reg_write(1'b0, 16'h0000); read_reg(1'b0, rd); check("R2 all zeros", rd, 16'h0040);
    reg_write(1'b0, 16'h5555); read_reg(1'b0, rd); check("R2 pattern 5555", rd, 16'h1440);
    reg_write(1'b0, 16'hAAAA); read_reg(1'b0, rd); check("R2 pattern AAAA", rd, 16'hA840);

    // R11 status reserved bits: write ones to them, nothing appears
    reg_write(1'b1, 16'hFFFF); read_reg(1'b1, rd); check("R11 status upper", rd, 16'h0000);

    // Sweep: SERR layering R4 R5 R6 R7 and first-error capture R8
    for (int c = 0; c < 8; c++) begin
      reg_write(1'b0, 16'h8000 | 16'(c << 10));
      for (int en = 0; en < 4; en++) begin
        cfg_serr_en = en[0]; cfg_perr_en = en[1];
        for (int e = 0; e < 32; e++) begin
          logic [4:0] ee;
          logic exp_s;
          ee = 5'(e);
          exp_s = en[0] & ((ee[0] & c[2] & en[1]) | (ee[1] & c[1]) | (ee[4] & c[0]));
          fire(ee, 1'b0);
          check("R4 R5 R6 serr qualify", {31'd0, serr_o}, {31'd0, exp_s});
          check("R7 serr copy", {31'd0, serr_copy_o}, {31'd0, serr_o});
          read_reg(1'b1, rd);
          if (c == 0 && en == 0) check("R8 lowest bit wins", rd, {8'h00, lowest(ee)});
          release_ev();
          reg_write(1'b1, 16'h00FF);
        end
      end
    end
    check("R7 serr falls", {31'd0, serr_o}, 32'd0);

    // R7 two consecutive event cycles give two high cycles
    reg_write(1'b0, 16'h8800); cfg_serr_en = 1'b1;
    ev = 5'b00010;
    @(posedge clk); #2; check("R7 first cycle", {31'd0, serr_o}, 32'd1);
    @(posedge clk); #2; check("R7 second cycle", {31'd0, serr_o}, 32'd1);
    @(negedge clk); ev = '0;
    @(posedge clk); #2; check("R7 drop", {31'd0, serr_o}, 32'd0);
    @(negedge clk);
    reg_write(1'b1, 16'h00FF);

    // R8 freeze
    fire(5'b01000, 1'b0); release_ev();
    fire(5'b00001, 1'b0); release_ev();
    fire(5'b10110, 1'b0); release_ev();
    read_reg(1'b1, rd); check("R8 frozen", rd, 16'h0008);

    // R9 write-1-to-clear
    reg_write(1'b1, 16'h0000); read_reg(1'b1, rd); check("R9 zero write", rd, 16'h0008);
    reg_write(1'b1, 16'h00F7); read_reg(1'b1, rd); check("R9 other bits", rd, 16'h0008);
    reg_write(1'b1, 16'h0008); read_reg(1'b1, rd); check("R9 clear", rd, 16'h0000);
    fire(5'b10000, 1'b0); release_ev();
    read_reg(1'b1, rd); check("R9 recapture", rd, 16'h0010);
    reg_write(1'b1, 16'h0010);

    // R10 interrupt level per single source
    reg_write(1'b0, 16'hA000);
    for (int s = 0; s < 5; s++) begin
      fire(5'(1 << s), 1'b0);
      check("R10 irq per source", {31'd0, irq_o}, {31'd0, (s == 2 || s == 3)});
      release_ev();
      reg_write(1'b1, 16'h00FF);
      check("R10 irq after clear", {31'd0, irq_o}, 32'd0);
    end
    reg_write(1'b0, 16'h8000);
    fire(5'b00100, 1'b0); release_ev();
    check("R10 irq disabled", {31'd0, irq_o}, 32'd0);
    reg_write(1'b0, 16'hA000);
    check("R10 irq on enable", {31'd0, irq_o}, 32'd1);
    reg_write(1'b1, 16'h0004);

    // R3 bus init and self-set override
    reg_write(1'b0, 16'h0000);
    fire(5'b00000, 1'b1);
    check("R3 bus init pulse", {31'd0, bus_init_o}, 32'd1);
    read_reg(1'b0, rd); check("R3 override set", rd, 16'h8040);
    @(posedge clk); #2;
    check("R3 pulse one cycle", {31'd0, bus_init_o}, 32'd0);
    release_ev();
    fire(5'b00000, 1'b1);
    check("R3 blocked", {31'd0, bus_init_o}, 32'd0);
    release_ev();
    reg_write(1'b0, 16'h0000);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0000; ev_fatal = 1'b1;
    @(posedge clk); #2;
    check("R3 race pulse", {31'd0, bus_init_o}, 32'd1);
    read_reg(1'b0, rd); check("R3 hw set wins", rd, 16'h8040);
    @(negedge clk);
    reg_wr = 1'b0; ev_fatal = 1'b0;
    read_reg(1'b1, rd); check("R8 fatal not recorded", rd, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule